// File: doc/BRIEF.md
# CPU Clock Source Switch Sequencer

This block moves a CPU cluster clock from one frequency to another without ever running the cores from a primary PLL that is relocking. It owns the two select fields of a two-level clock mux tree. The first level is a four-input primary mux that feeds the cores. The second level is a two-input secondary mux that feeds input 0 of the primary mux. The analog PLLs, the droop detector and the muxes are outside the block. They appear only as the select outputs, a program strobe with a frequency value, a droop-setup pulse and a lock input.

A rate change starts with a request that carries a target frequency in kHz. The block checks the target and refuses anything below the legal floor. For a legal target it parks the cores on the alternate PLL and fires the droop-setup pulse. It then programs the primary PLL and waits for a fresh lock. Last, it selects the final path:
- For targets at or above the split point, the final path is the full-rate droop-detection branch.
- Below the split point, the PLL is programmed to twice the target, so it stays inside its lock range, and the cores take the divided output through the secondary mux.

Software can write either select field directly through the mux register while the block is idle. A request for the raw PLL input is always stored as the droop-detection input.

Top module: `cpu_clk_switch_seq`

## Requirements
- R1: After reset the primary select is 0, the secondary select is 0, and busy, done, err_low and overrun are all low.
- R2: The mux register reads as {secondary select, primary select}: bits [3:2] hold the secondary select and bits [1:0] hold the primary select. A write with only sw_wr_pri set changes only bits [1:0]. A write with only sw_wr_sec set changes only bits [3:2].
- R3: The primary select never holds code 1, the raw PLL. A write of code 1 is stored as code 2, the droop-detection branch. The other primary codes are 0 = secondary mux, 2 = droop branch and 3 = alternate PLL. The secondary codes are 0 = crystal and 1 = PLL divided by two.
- R4: For a legal request the primary select becomes 3 before the PLL program strobe. Exactly one droop-setup pulse is issued per park, in the first cycle in which the primary select reads 3.
- R5: pll_prog_stb is a single-cycle pulse, issued once per legal request. It carries twice the target when the target is below 600000 kHz, and the target itself otherwise. The value carried is never below 600000 kHz.
- R6: The final selection happens only after the lock input has gone low and then high again following the program strobe. Until then the primary select stays at 3.
- R7: For a target below 600000 kHz, the block first sets the secondary select to 1 and then sets the primary select to 0. For a target of 600000 kHz or more, it sets the primary select to 2 and leaves the secondary select unchanged.
- R8: A target below 300000 kHz sets err_low. In that case no select changes, and neither strobe nor done is issued. err_low clears when the next request is accepted.
- R9: busy is high from the cycle after an accepted request until the block returns to idle. done pulses for one cycle at the end of a successful switch.
- R10: A request that arrives while busy is ignored, so the running switch finishes with its original target, and it sets overrun, which stays set until reset.
- R11: Once the mux register value changes, it holds for at least MIN_HOLD cycles (default 2) before it changes again.
- R12: A software write is dropped when the block is busy, or when it arrives inside the hold window of R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Rate-change request, one cycle |
| req_khz | input | 32 | Target frequency in kHz, unsigned |
| sw_wr_pri | input | 1 | Software write of the primary select field |
| sw_wr_sec | input | 1 | Software write of the secondary select field |
| sw_wr_data | input | 4 | Write data: [1:0] primary, [3:2] secondary |
| sel_reg | output | 4 | Mux register readback {secondary, primary} |
| pri_sel | output | 2 | Primary mux select |
| sec_sel | output | 2 | Secondary mux select |
| pll_lock | input | 1 | Primary PLL lock indication |
| pll_prog_stb | output | 1 | One-cycle strobe that programs the primary PLL |
| pll_prog_khz | output | 32 | Primary PLL frequency in kHz, valid with the strobe |
| droop_setup_stb | output | 1 | Pulse that starts the droop-detector setup on each park |
| busy | output | 1 | Switch sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a successful switch |
| err_low | output | 1 | Last accepted target was below the floor |
| overrun | output | 1 | Sticky flag for a request received while busy |

## Verification
The assertions assume that the lock input drops some time after each program strobe and rises again later. They also assume that software writes and requests arrive only on clock edges with synchronous reset released. The bench meets both assumptions with a PLL model that clears lock in the cycle after the strobe and sets it again after a random delay. Random targets span both sides of the floor and of the split point. Directed cases hit the exact boundaries at 299999, 300000, 599999 and 600000 kHz. Software writes are aimed on purpose at busy periods and at the hold window, where the block must drop them.

// File: rtl/cks_pkg.sv
`timescale 1ns/1ps
package cks_pkg;
    localparam int KHZ_W = 32;
    localparam int SEL_W = 2;

    // primary mux input codes
    localparam logic [SEL_W-1:0] PRI_SMUX  = 2'd0;
    localparam logic [SEL_W-1:0] PRI_RAW   = 2'd1;
    localparam logic [SEL_W-1:0] PRI_DROOP = 2'd2;
    localparam logic [SEL_W-1:0] PRI_ALT   = 2'd3;
    // secondary mux input codes
    localparam logic [SEL_W-1:0] SEC_XO    = 2'd0;
    localparam logic [SEL_W-1:0] SEC_HALF  = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_PARK, ST_PROG, ST_WAIT_LOCK, ST_FINAL, ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic             legal;
        logic             halve;
        logic [KHZ_W-1:0] vco_khz;
    } rate_plan_t;

    typedef struct packed {
        logic             set_pri;
        logic             set_sec;
        logic [SEL_W-1:0] pri;
        logic [SEL_W-1:0] sec;
    } sel_cmd_t;

    localparam sel_cmd_t SEL_CMD_NONE = '0;

    // the raw PLL input is never used directly: route it through the droop branch
    function automatic logic [SEL_W-1:0] fold_raw(input logic [SEL_W-1:0] code);
        return (code == PRI_RAW) ? PRI_DROOP : code;
    endfunction

    function automatic sel_cmd_t cmd_pri(input logic [SEL_W-1:0] code);
        sel_cmd_t c;
        c         = SEL_CMD_NONE;
        c.set_pri = 1'b1;
        c.pri     = code;
        return c;
    endfunction

    function automatic sel_cmd_t cmd_sec(input logic [SEL_W-1:0] code);
        sel_cmd_t c;
        c         = SEL_CMD_NONE;
        c.set_sec = 1'b1;
        c.sec     = code;
        return c;
    endfunction
endpackage

// File: rtl/cks_rate_plan.sv
`timescale 1ns/1ps
module cks_rate_plan
    import cks_pkg::*;
#(
    parameter logic [KHZ_W-1:0] FLOOR_KHZ = 32'd300000,
    parameter logic [KHZ_W-1:0] SPLIT_KHZ = 32'd600000
) (
    input  logic [KHZ_W-1:0] target_khz,
    output rate_plan_t       plan
);
    logic below_split;

    always_comb begin
        below_split  = (target_khz < SPLIT_KHZ);
        plan.legal   = (target_khz >= FLOOR_KHZ);
        plan.halve   = below_split;
        // lock range starts at the split point: run the VCO at twice the target
        plan.vco_khz = below_split ? {target_khz[KHZ_W-2:0], 1'b0} : target_khz;
    end
endmodule

// File: rtl/cks_sel_reg.sv
`timescale 1ns/1ps
module cks_sel_reg
    import cks_pkg::*;
#(
    parameter int unsigned MIN_HOLD = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  sel_cmd_t         cmd,
    output logic [SEL_W-1:0] pri_q,
    output logic [SEL_W-1:0] sec_q,
    output logic             settled
);
    localparam int AGE_W = $clog2(MIN_HOLD + 1);
    localparam logic [AGE_W-1:0] AGE_FULL = AGE_W'(MIN_HOLD);
    localparam logic [AGE_W-1:0] AGE_ONE  = AGE_W'(1);

    logic [SEL_W-1:0] pri_d, sec_d;
    logic [AGE_W-1:0] age;
    logic             changed;

    always_comb begin
        pri_d   = cmd.set_pri ? fold_raw(cmd.pri) : pri_q;
        sec_d   = cmd.set_sec ? cmd.sec : sec_q;
        changed = ({sec_d, pri_d} != {sec_q, pri_q});
        settled = (age >= AGE_FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pri_q <= PRI_SMUX;
            sec_q <= SEC_XO;
            age   <= AGE_FULL;
        end else begin
            pri_q <= pri_d;
            sec_q <= sec_d;
            if (changed)
                age <= AGE_ONE;
            else if (age < AGE_FULL)
                age <= age + AGE_ONE;
        end
    end

    // R3: raw PLL code is never held
    a_r3_no_raw: assert property (@(posedge clk) disable iff (rst)
        pri_q != PRI_RAW);
    // R2: a primary-only write leaves the secondary field alone
    a_r2_keep_sec: assert property (@(posedge clk) disable iff (rst)
        (cmd.set_pri && !cmd.set_sec) |=> $stable(sec_q));
    // R2: a secondary-only write leaves the primary field alone
    a_r2_keep_pri: assert property (@(posedge clk) disable iff (rst)
        (cmd.set_sec && !cmd.set_pri) |=> $stable(pri_q));
endmodule

// File: rtl/cks_seq_fsm.sv
`timescale 1ns/1ps
module cks_seq_fsm
    import cks_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [KHZ_W-1:0] req_khz,
    input  rate_plan_t       plan,
    input  logic             settled,
    input  logic             pll_lock,
    output logic [KHZ_W-1:0] target_q,
    output sel_cmd_t         seq_cmd,
    output logic             busy,
    output logic             done,
    output logic             droop_stb,
    output logic             prog_stb,
    output logic [KHZ_W-1:0] prog_khz,
    output logic             err_low,
    output logic             overrun
);
    seq_state_e state, state_d;
    logic       fin_step, fin_step_d;
    logic       unlock_seen;

    always_comb begin
        state_d    = state;
        seq_cmd    = SEL_CMD_NONE;
        fin_step_d = fin_step;
        case (state)
            ST_IDLE:      if (req_valid) state_d = ST_CHECK;
            ST_CHECK:     state_d = plan.legal ? ST_PARK : ST_IDLE;
            ST_PARK: begin
                if (settled) begin
                    seq_cmd = cmd_pri(PRI_ALT);
                    state_d = ST_PROG;
                end
            end
            ST_PROG:      state_d = ST_WAIT_LOCK;
            ST_WAIT_LOCK: if (unlock_seen && pll_lock) state_d = ST_FINAL;
            ST_FINAL: begin
                if (settled) begin
                    if (plan.halve && !fin_step) begin
                        seq_cmd    = cmd_sec(SEC_HALF);
                        fin_step_d = 1'b1;
                    end else begin
                        seq_cmd = cmd_pri(plan.halve ? PRI_SMUX : PRI_DROOP);
                        state_d = ST_DONE;
                    end
                end
            end
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            target_q    <= '0;
            fin_step    <= 1'b0;
            unlock_seen <= 1'b0;
            droop_stb   <= 1'b0;
            prog_stb    <= 1'b0;
            prog_khz    <= '0;
            err_low     <= 1'b0;
            overrun     <= 1'b0;
        end else begin
            state     <= state_d;
            fin_step  <= (state == ST_FINAL) ? fin_step_d : 1'b0;
            droop_stb <= (state == ST_PARK) && settled;
            prog_stb  <= (state == ST_PROG);
            if (state == ST_PROG)
                prog_khz <= plan.vco_khz;
            if (state == ST_PROG)
                unlock_seen <= 1'b0;
            else if (state == ST_WAIT_LOCK && !pll_lock)
                unlock_seen <= 1'b1;
            if (state == ST_IDLE && req_valid) begin
                target_q <= req_khz;
                err_low  <= 1'b0;
            end
            if (state == ST_CHECK && !plan.legal)
                err_low <= 1'b1;
            if (state != ST_IDLE && req_valid)
                overrun <= 1'b1;
        end
    end

    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end

    // R10: a request while busy raises the sticky flag
    a_r10_overrun: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy) |=> overrun);
    // R5: program strobe lasts one cycle
    a_r5_one_pulse: assert property (@(posedge clk) disable iff (rst)
        prog_stb |=> !prog_stb);
    // R8: a rejected target returns to idle with the error raised
    a_r8_reject: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && !plan.legal) |=> (!busy && err_low));
    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/cpu_clk_switch_seq.sv
`timescale 1ns/1ps
module cpu_clk_switch_seq
    import cks_pkg::*;
#(
    parameter logic [31:0] FLOOR_KHZ = 32'd300000,
    parameter logic [31:0] SPLIT_KHZ = 32'd600000,
    parameter int unsigned MIN_HOLD  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_khz,
    input  logic        sw_wr_pri,
    input  logic        sw_wr_sec,
    input  logic [3:0]  sw_wr_data,
    output logic [3:0]  sel_reg,
    output logic [1:0]  pri_sel,
    output logic [1:0]  sec_sel,
    input  logic        pll_lock,
    output logic        pll_prog_stb,
    output logic [31:0] pll_prog_khz,
    output logic        droop_setup_stb,
    output logic        busy,
    output logic        done,
    output logic        err_low,
    output logic        overrun
);
    rate_plan_t       plan;
    sel_cmd_t         seq_cmd, sw_cmd, mux_cmd;
    logic [KHZ_W-1:0] target_q;
    logic             settled;

    cks_rate_plan #(.FLOOR_KHZ(FLOOR_KHZ), .SPLIT_KHZ(SPLIT_KHZ)) u_plan (
        .target_khz (target_q),
        .plan       (plan)
    );

    cks_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_khz   (req_khz),
        .plan      (plan),
        .settled   (settled),
        .pll_lock  (pll_lock),
        .target_q  (target_q),
        .seq_cmd   (seq_cmd),
        .busy      (busy),
        .done      (done),
        .droop_stb (droop_setup_stb),
        .prog_stb  (pll_prog_stb),
        .prog_khz  (pll_prog_khz),
        .err_low   (err_low),
        .overrun   (overrun)
    );

    always_comb begin
        sw_cmd.set_pri = sw_wr_pri;
        sw_cmd.set_sec = sw_wr_sec;
        sw_cmd.pri     = sw_wr_data[1:0];
        sw_cmd.sec     = sw_wr_data[3:2];
        // sequencer owns the register while busy; software waits out the hold window
        if (busy)
            mux_cmd = seq_cmd;
        else if (settled)
            mux_cmd = sw_cmd;
        else
            mux_cmd = SEL_CMD_NONE;
    end

    cks_sel_reg #(.MIN_HOLD(MIN_HOLD)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .cmd     (mux_cmd),
        .pri_q   (pri_sel),
        .sec_q   (sec_sel),
        .settled (settled)
    );

    assign sel_reg = {sec_sel, pri_sel};

    // independent observer of the register age for R11
    localparam int CHK_W = $clog2(MIN_HOLD + 1);
    logic [3:0]       chk_last;
    logic [CHK_W-1:0] chk_age;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_last <= 4'd0;
            chk_age  <= CHK_W'(MIN_HOLD);
        end else begin
            chk_last <= sel_reg;
            if (sel_reg != chk_last)
                chk_age <= CHK_W'(1);
            else if (chk_age < CHK_W'(MIN_HOLD))
                chk_age <= chk_age + CHK_W'(1);
        end
    end

    // R11: previous value was held long enough before each change
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (sel_reg != chk_last) |-> (chk_age >= CHK_W'(MIN_HOLD)));
    // R4: parked on the alternate PLL while programming
    a_r4_park_first: assert property (@(posedge clk) disable iff (rst)
        pll_prog_stb |-> (pri_sel == PRI_ALT));
    // R4: droop setup fires while parked
    a_r4_droop_parked: assert property (@(posedge clk) disable iff (rst)
        droop_setup_stb |-> (pri_sel == PRI_ALT));
    // R5: programmed value inside the lock range
    a_r5_range: assert property (@(posedge clk) disable iff (rst)
        pll_prog_stb |-> (pll_prog_khz >= SPLIT_KHZ));
    // R7: finishing path is one of the two legal ones
    a_r7_final_path: assert property (@(posedge clk) disable iff (rst)
        done |-> ((pri_sel == PRI_SMUX && sec_sel == SEC_HALF) || pri_sel == PRI_DROOP));
    // R9: busy stays up while done is shown
    a_r9_busy_done: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
endmodule

// File: tb/cpu_clk_switch_seq_tb.sv
`timescale 1ns/1ps
module cpu_clk_switch_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_khz = '0;
    logic        sw_wr_pri = 1'b0;
    logic        sw_wr_sec = 1'b0;
    logic [3:0]  sw_wr_data = '0;
    logic [3:0]  sel_reg;
    logic [1:0]  pri_sel, sec_sel;
    logic        pll_lock = 1'b1;
    logic        pll_prog_stb;
    logic [31:0] pll_prog_khz;
    logic        droop_setup_stb, busy, done, err_low, overrun;

    int checks = 0;
    int errors = 0;
    int lock_dly = 4;
    int droop_n, prog_n, done_n, hold_bad, park_bad, early_bad;
    logic [31:0] prog_val;
    logic [3:0]  last_sel = 4'd0;
    int gap = 1000;
    int lock_cnt = 0;
    bit wait_lock = 1'b0;

    always #5 clk = ~clk;

    cpu_clk_switch_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_khz(req_khz),
        .sw_wr_pri(sw_wr_pri), .sw_wr_sec(sw_wr_sec), .sw_wr_data(sw_wr_data),
        .sel_reg(sel_reg), .pri_sel(pri_sel), .sec_sel(sec_sel),
        .pll_lock(pll_lock), .pll_prog_stb(pll_prog_stb), .pll_prog_khz(pll_prog_khz),
        .droop_setup_stb(droop_setup_stb), .busy(busy), .done(done),
        .err_low(err_low), .overrun(overrun)
    );

    function automatic bit exp_legal(input logic [31:0] k);  return k >= 32'd300000; endfunction
    function automatic bit exp_halve(input logic [31:0] k);  return k < 32'd600000; endfunction
    function automatic logic [31:0] exp_prog(input logic [31:0] k);
        return exp_halve(k) ? k * 2 : k;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor and PLL lock model in one process so sampling order is fixed
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (sel_reg != last_sel) begin
                    if (gap < 2) hold_bad++;
                    gap = 1;
                end else if (gap < 1000) gap++;
                last_sel = sel_reg;
                if (droop_setup_stb) begin droop_n++; if (pri_sel != 2'd3) park_bad++; end
                if (pll_prog_stb) begin
                    prog_n++; prog_val = pll_prog_khz;
                    if (pri_sel != 2'd3) park_bad++;
                end
                if (done) done_n++;
                if (wait_lock && pri_sel != 2'd3) early_bad++;
            end
            if (pll_prog_stb) begin
                pll_lock = 1'b0; lock_cnt = lock_dly; wait_lock = 1'b1;
            end else if (!pll_lock) begin
                if (lock_cnt == 0) begin pll_lock = 1'b1; wait_lock = 1'b0; end
                else lock_cnt--;
            end
        end
    end

    task automatic clear_counts();
        droop_n = 0; prog_n = 0; done_n = 0; park_bad = 0; early_bad = 0; prog_val = '0;
    endtask

    task automatic sw_write(input bit p, input bit s, input logic [3:0] d);
        @(negedge clk);
        sw_wr_pri = p; sw_wr_sec = s; sw_wr_data = d;
        @(negedge clk);
        sw_wr_pri = 1'b0; sw_wr_sec = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        int wd = 0;
        while (busy && wd < 3000) begin @(negedge clk); wd++; end
        chk(!busy, "R9 sequence returns to idle", 32'(busy), 0);
    endtask

    task automatic issue(input logic [31:0] k);
        @(negedge clk);
        req_valid = 1'b1; req_khz = k;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_req(input logic [31:0] k);
        logic [1:0] sec_before;
        logic [3:0] sel_before;
        sec_before = sec_sel;
        sel_before = sel_reg;
        clear_counts();
        issue(k);
        chk(busy == 1'b1, "R9 busy after request", 32'(busy), 1);
        wait_idle();
        idle_cycles(1);
        if (!exp_legal(k)) begin
            chk(err_low == 1'b1, "R8 err_low on low target", 32'(err_low), 1);
            chk(sel_reg == sel_before, "R8 selects unchanged", 32'(sel_reg), 32'(sel_before));
            chk(prog_n == 0 && droop_n == 0 && done_n == 0, "R8 no strobes",
                32'(prog_n + droop_n + done_n), 0);
        end else begin
            chk(err_low == 1'b0, "R8 err_low clear after legal", 32'(err_low), 0);
            chk(prog_n == 1, "R5 one program strobe", 32'(prog_n), 1);
            chk(prog_val == exp_prog(k), "R5 program value", prog_val, exp_prog(k));
            chk(droop_n == 1, "R4 one droop pulse", 32'(droop_n), 1);
            chk(park_bad == 0, "R4 parked before program", 32'(park_bad), 0);
            chk(early_bad == 0, "R6 parked until relock", 32'(early_bad), 0);
            chk(done_n == 1, "R9 one done pulse", 32'(done_n), 1);
            if (exp_halve(k)) begin
                chk(pri_sel == 2'd0, "R7 half path primary", 32'(pri_sel), 0);
                chk(sec_sel == 2'd1, "R7 half path secondary", 32'(sec_sel), 1);
            end else begin
                chk(pri_sel == 2'd2, "R7 full path primary", 32'(pri_sel), 2);
                chk(sec_sel == sec_before, "R7 full path secondary kept", 32'(sec_sel), 32'(sec_before));
            end
        end
        chk(hold_bad == 0, "R11 hold window", 32'(hold_bad), 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_counts();
        hold_bad = 0;
        idle_cycles(3);
        rst = 1'b0;
        idle_cycles(1);
        // R1
        chk(pri_sel == 0 && sec_sel == 0, "R1 reset selects", 32'(sel_reg), 0);
        chk({busy, done, err_low, overrun} == 4'b0, "R1 reset flags",
            32'({busy, done, err_low, overrun}), 0);

        // R2 field-isolated writes
        sw_write(1'b1, 1'b0, 4'b0110);
        idle_cycles(1);
        chk(sel_reg == 4'b0010, "R2 primary-only write", 32'(sel_reg), 32'h2);
        idle_cycles(2);
        sw_write(1'b0, 1'b1, 4'b0111);
        idle_cycles(1);
        chk(sel_reg == 4'b0110, "R2 secondary-only write", 32'(sel_reg), 32'h6);
        idle_cycles(2);
        // R3 raw code remap
        sw_write(1'b1, 1'b0, 4'b0000);
        idle_cycles(2);
        sw_write(1'b1, 1'b0, 4'b0001);
        idle_cycles(1);
        chk(pri_sel == 2'd2, "R3 raw code stored as droop", 32'(pri_sel), 2);
        idle_cycles(2);
        // R12 write inside hold window is dropped
        @(negedge clk); sw_wr_pri = 1'b1; sw_wr_data = 4'b0011;
        @(negedge clk); sw_wr_pri = 1'b0; sw_wr_sec = 1'b1; sw_wr_data = 4'b0000;
        @(negedge clk); sw_wr_sec = 1'b0;
        idle_cycles(1);
        chk(sel_reg == 4'b0111, "R12 write in hold window dropped", 32'(sel_reg), 32'h7);
        idle_cycles(2);

        // directed boundaries
        run_req(32'd299999);
        run_req(32'd300000);
        run_req(32'd599999);
        run_req(32'd600000);
        run_req(32'd2000000);
        run_req(32'd100);

        // R10 request while busy
        clear_counts();
        issue(32'd800000);
        @(negedge clk); req_valid = 1'b1; req_khz = 32'd400000;
        @(negedge clk); req_valid = 1'b0;
        wait_idle();
        idle_cycles(1);
        chk(overrun == 1'b1, "R10 overrun set", 32'(overrun), 1);
        chk(prog_val == 32'd800000 && prog_n == 1, "R10 original target kept", prog_val, 32'd800000);
        chk(pri_sel == 2'd2, "R10 original path kept", 32'(pri_sel), 2);

        // R12 write while busy is dropped
        clear_counts();
        lock_dly = 8;
        issue(32'd450000);
        idle_cycles(4);
        sw_write(1'b1, 1'b1, 4'b1000);
        wait_idle();
        idle_cycles(1);
        chk(pri_sel == 2'd0 && sec_sel == 2'd1, "R12 write while busy dropped", 32'(sel_reg), 32'h4);
        chk(overrun == 1'b1, "R10 overrun sticky", 32'(overrun), 1);

        // random targets and lock delays
        for (int i = 0; i < 30; i++) begin
            lock_dly = $urandom_range(12, 0);
            run_req($urandom_range(2200000, 250000));
            idle_cycles($urandom_range(3, 0));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule